// File: doc/BRIEF.md
# Two-wire control register bank with indirect memory window

This block sits behind the byte-level front end of a two-wire serial slave (the front end answers to the 7-bit address 0010001 followed by the read/write bit). It receives decoded register writes and read requests, keeps the configuration registers at addresses 0x00 to 0x0A, and presents the configuration fields as plain output pins. The first byte of every write transfer is the register pointer. Every data byte, written or read, moves the pointer on by one.

Address 0x0B is a window onto display memory, not a storage location. A write there always sends the byte to memory, at the chapter chosen by register 0x08 and at the row and column held in registers 0x09 and 0x0A. A read there returns either the memory byte at that position or a status byte built from the sync-quality inputs. Bit 0 of register 0x00 makes that choice. Each completed memory access steps the column, so the host can stream a whole row in one transfer.

Byte traffic uses valid/ready handshakes. The front end holds `wr_valid` or `rd_req_valid` with stable data until the matching ready is seen high at a clock edge. Read results stay on `rd_data` with `rd_valid` until the front end takes them with `rd_ready`. The memory request holds its fields until `mem_req_ready`. A read response arrives as a single-cycle `mem_rsp_valid` pulse, which the block accepts in any cycle.

Top module: `sbus_regbank`

## Requirements
- R1: After reset, registers 0x05 and 0x06 hold 0x03. Every other register, the active row and the active column hold 0. No request or read result is valid.
- R2: A write byte flagged `wr_first` loads the pointer. Each other write byte is stored at the pointer, and the pointer then advances by one. At 0x0B it stays at 0x0B. Reads also advance the pointer.
- R3: Reserved bits are stored as 0 whatever is written. The writable masks are: 0x00 to 0x07, 0x01 to 0x7F, 0x02 to 0xBF (bit 6 reserved), 0x03 to 0x1F, 0x04 to 0x03, 0x08 to 0x07, 0x09 to 0x1F, 0x0A to 0x3F. Registers 0x05, 0x06 and 0x07 take all eight bits.
- R4: Reads of 0x00 to 0x0A, and of any address above 0x0B, return 0x00 without a memory access. Writes above 0x0B change nothing.
- R5: When register 0x00 bit 0 is 1, a read of 0x0B returns bit 7 = `rate_60hz` and bit 0 = `sync_good`, with bits 6 to 1 equal to 0. It makes no memory access and leaves the column unchanged.
- R6: When register 0x00 bit 0 is 0, a read of 0x0B issues a memory read at (chapter, row, column) and returns the response byte.
- R7: A write to 0x0B always issues a memory write of that byte at (chapter, row, column), whatever the value of register 0x00 bit 0.
- R8: Each accepted memory write, and each memory read response, advances the column by one. After column 39 the column returns to 0 and the row advances. After row 24 the row returns to 0.
- R9: A write to 0x09 sets the row from bits 4:0. A write to 0x0A sets the column from bits 5:0. Register 0x08 drives `mem_chapter` from bits 1:0 and `mem_pkt_sel` from bit 2.
- R10: The memory request keeps its fields stable until it is accepted. `rd_valid` and `rd_data` hold until `rd_ready`. `wr_ready` and `rd_req_ready` are low while any window access or read result is outstanding. `rd_req_ready` is also low while `wr_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted at this edge |
| wr_first | input | 1 | Byte is the register pointer |
| wr_data | input | 8 | Write byte |
| rd_req_valid | input | 1 | Read of the pointed register requested |
| rd_req_ready | output | 1 | Read request accepted |
| rd_valid | output | 1 | Read result available |
| rd_ready | input | 1 | Front end takes the read result |
| rd_data | output | 8 | Read result |
| sync_good | input | 1 | Sync signal quality good |
| rate_60hz | input | 1 | Field rate is 60 Hz (meaningful only with sync_good) |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for write, 0 for read |
| mem_chapter | output | 2 | Page (chapter) selected for access |
| mem_pkt_sel | output | 1 | Auxiliary-packet access selected |
| mem_row | output | 5 | Active row |
| mem_col | output | 6 | Active column |
| mem_wdata | output | 8 | Memory write byte |
| mem_rsp_valid | input | 1 | Memory read data valid (one cycle) |
| mem_rsp_data | input | 8 | Memory read data |
| cfg_pins | output | 3 | Register 0x00 (bit 0 selects status on reads) |
| cfg_mode | output | 7 | Register 0x01 operating mode |
| preq_ctl | output | 8 | Register 0x02 page-request addressing |
| preq_data | output | 5 | Register 0x03 page-request data |
| disp_page | output | 2 | Register 0x04 page shown |
| disp_norm | output | 8 | Register 0x05 normal display control |
| disp_flash | output | 8 | Register 0x06 newsflash/subtitle display control |
| disp_mode | output | 8 | Register 0x07 display mode |

## Verification
The assertions check several rules on every cycle. A pending memory request keeps its direction, row and column until it is accepted. A read result holds until the front end takes it. The column steps by one, or wraps to zero, after each accepted memory write. The pointer stays on the window address. A status read never starts a memory request. The reset value of registers 0x05 and 0x06 is also checked.

Other behaviour only the bench scenarios can show. These cover the masking of reserved bits, zero data from write-only and unmapped addresses, and the read path switching between status and memory while writes always reach memory. The bench also follows the row and column across the 39-to-0 and 24-to-0 wraps. Under back-pressure on both the memory and read sides, it confirms that every memory write and every read byte carries the address and data its own model predicts.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int NCFG = 9;
  localparam logic [7:0] A_ROW = 8'h09;
  localparam logic [7:0] A_COL = 8'h0A;
  localparam logic [7:0] A_WIN = 8'h0B;

  typedef enum logic [2:0] {W_IDLE, W_MEMW, W_MEMR, W_MEMRSP, W_RDOUT} win_st_t;

  function automatic logic [7:0] cfg_mask(int idx);
    case (idx)
      0: cfg_mask = 8'h07;
      1: cfg_mask = 8'h7F;
      2: cfg_mask = 8'hBF;
      3: cfg_mask = 8'h1F;
      4: cfg_mask = 8'h03;
      8: cfg_mask = 8'h07;
      default: cfg_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] cfg_rst(int idx);
    cfg_rst = (idx == 5 || idx == 6) ? 8'h03 : 8'h00;
  endfunction
endpackage

// File: rtl/sbus_ptr.sv
module sbus_ptr
  import sbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  output logic [7:0] ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ptr <= 8'h00;
    else if (load)        ptr <= load_val;
    else if (step && ptr != A_WIN) ptr <= ptr + 8'h01;
  end

  // R2: the window address is sticky for data bytes
  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && ptr == A_WIN) |=> ptr == A_WIN);
endmodule

// File: rtl/sbus_cfg.sv
module sbus_cfg
  import sbus_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [3:0]            waddr,
  input  logic [7:0]            wdata,
  output logic [NCFG-1:0][7:0]  regs
);
  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   q <= cfg_rst(g);
      else if (we && waddr == 4'(g)) q <= wdata & cfg_mask(g);
    end
    assign regs[g] = q;
  end

  // R1: display control registers come out of reset at 0x03
  p_rst_disp_r1: assert property (@(posedge clk)
    !rst_n |=> (regs[5] == 8'h03 && regs[6] == 8'h03 && regs[0] == 8'h00));
endmodule

// File: rtl/sbus_window.sv
module sbus_window
  import sbus_pkg::*;
#(
  parameter int ROWS = 25,
  parameter int COLS = 40,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_we,
  input  logic             col_we,
  input  logic             win_wr,
  input  logic             rd_mem,
  input  logic             rd_imm,
  input  logic [7:0]       wdata,
  input  logic [7:0]       imm_data,
  output logic             idle,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic [7:0]       mem_wdata,
  input  logic             mem_rsp_valid,
  input  logic [7:0]       mem_rsp_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data
);
  win_st_t          st;
  logic [7:0]       wbuf, rbuf;
  logic [ROW_W-1:0] nrow;
  logic [COL_W-1:0] ncol;

  always_comb begin
    nrow = row;
    ncol = col + 1'b1;
    if (col >= COL_W'(COLS - 1)) begin
      ncol = '0;
      nrow = (row >= ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= W_IDLE; row <= '0; col <= '0; wbuf <= '0; rbuf <= '0;
    end else begin
      case (st)
        W_IDLE: begin
          if (row_we) row <= wdata[ROW_W-1:0];
          if (col_we) col <= wdata[COL_W-1:0];
          if (win_wr) begin
            wbuf <= wdata; st <= W_MEMW;
          end else if (rd_mem) begin
            st <= W_MEMR;
          end else if (rd_imm) begin
            rbuf <= imm_data; st <= W_RDOUT;
          end
        end
        W_MEMW: if (mem_req_ready) begin
          row <= nrow; col <= ncol; st <= W_IDLE;
        end
        W_MEMR: if (mem_req_ready) st <= W_MEMRSP;
        W_MEMRSP: if (mem_rsp_valid) begin
          rbuf <= mem_rsp_data; row <= nrow; col <= ncol; st <= W_RDOUT;
        end
        W_RDOUT: if (rd_ready) st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign idle          = (st == W_IDLE);
  assign mem_req_valid = (st == W_MEMW) || (st == W_MEMR);
  assign mem_req_write = (st == W_MEMW);
  assign mem_wdata     = wbuf;
  assign rd_valid      = (st == W_RDOUT);
  assign rd_data       = rbuf;

  // R10: request fields held until accepted
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(row) && $stable(col)));
  // R10: read result held until taken
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R8: column wrap after the last column
  p_col_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready && col == COL_W'(COLS - 1))
      |=> col == '0);
  // R8: column step inside a row
  p_col_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready && col < COL_W'(COLS - 1))
      |=> col == COL_W'($past(col) + 1'b1));
endmodule

// File: rtl/sbus_regbank.sv
module sbus_regbank
  import sbus_pkg::*;
#(
  parameter int ROWS = 25,
  parameter int COLS = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic                     wr_first,
  input  logic [7:0]               wr_data,
  input  logic                     rd_req_valid,
  output logic                     rd_req_ready,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [7:0]               rd_data,
  input  logic                     sync_good,
  input  logic                     rate_60hz,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_write,
  output logic [1:0]               mem_chapter,
  output logic                     mem_pkt_sel,
  output logic [$clog2(ROWS)-1:0]  mem_row,
  output logic [$clog2(COLS)-1:0]  mem_col,
  output logic [7:0]               mem_wdata,
  input  logic                     mem_rsp_valid,
  input  logic [7:0]               mem_rsp_data,
  output logic [2:0]               cfg_pins,
  output logic [6:0]               cfg_mode,
  output logic [7:0]               preq_ctl,
  output logic [4:0]               preq_data,
  output logic [1:0]               disp_page,
  output logic [7:0]               disp_norm,
  output logic [7:0]               disp_flash,
  output logic [7:0]               disp_mode
);
  logic [7:0]            ptr;
  logic [NCFG-1:0][7:0]  regs;
  logic wr_fire, rd_fire, dwr, win_idle, sel_status, at_win;
  logic rd_mem, rd_imm;
  logic [7:0] imm_data;

  assign wr_ready     = win_idle;
  assign rd_req_ready = win_idle && !wr_valid;
  assign wr_fire      = wr_valid && wr_ready;
  assign rd_fire      = rd_req_valid && rd_req_ready;
  assign dwr          = wr_fire && !wr_first;
  assign at_win       = (ptr == A_WIN);
  assign sel_status   = regs[0][0];
  assign rd_mem       = rd_fire && at_win && !sel_status;
  assign rd_imm       = rd_fire && !(at_win && !sel_status);
  assign imm_data     = at_win ? {rate_60hz, 6'b000000, sync_good} : 8'h00;

  sbus_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(wr_fire && wr_first), .load_val(wr_data),
    .step(dwr || rd_fire), .ptr(ptr)
  );

  sbus_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(dwr && ptr < 8'(NCFG)), .waddr(ptr[3:0]),
    .wdata(wr_data), .regs(regs)
  );

  sbus_window #(.ROWS(ROWS), .COLS(COLS)) u_win (
    .clk(clk), .rst_n(rst_n),
    .row_we(dwr && ptr == A_ROW), .col_we(dwr && ptr == A_COL),
    .win_wr(dwr && at_win), .rd_mem(rd_mem), .rd_imm(rd_imm),
    .wdata(wr_data), .imm_data(imm_data), .idle(win_idle),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .row(mem_row), .col(mem_col),
    .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data)
  );

  assign cfg_pins    = regs[0][2:0];
  assign cfg_mode    = regs[1][6:0];
  assign preq_ctl    = regs[2];
  assign preq_data   = regs[3][4:0];
  assign disp_page   = regs[4][1:0];
  assign disp_norm   = regs[5];
  assign disp_flash  = regs[6];
  assign disp_mode   = regs[7];
  assign mem_chapter = regs[8][1:0];
  assign mem_pkt_sel = regs[8][2];

  // R5: a status read never reaches memory
  p_stat_nomem_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && at_win && sel_status) |=> (!mem_req_valid && rd_valid));
endmodule

// File: tb/sbus_regbank_bench.sv
module sbus_regbank_bench;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_first = 0, rd_req_valid = 0, rd_ready = 0;
  logic [7:0] wr_data = 0;
  logic sync_good = 0, rate_60hz = 0, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [7:0] mem_rsp_data = 0;
  logic wr_ready, rd_req_ready, rd_valid, mem_req_valid, mem_req_write, mem_pkt_sel;
  logic [7:0] rd_data, mem_wdata, preq_ctl, disp_norm, disp_flash, disp_mode;
  logic [1:0] mem_chapter, disp_page;
  logic [4:0] mem_row, preq_data;
  logic [5:0] mem_col;
  logic [2:0] cfg_pins;
  logic [6:0] cfg_mode;

  always #10 clk = ~clk;

  sbus_regbank u_sbus_regbank (.*);

  int checks = 0, errors = 0, cyc = 0, mem_acc = 0;
  logic [7:0]  rexp[$];
  logic [20:0] wexp[$];
  logic        pend = 0;
  logic [7:0]  pdata = 0;
  logic [7:0]  bptr = 0;
  logic [1:0]  bch = 0;
  logic [4:0]  trow = 0;
  logic [5:0]  tcol = 0;
  logic        bsel = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_fn(input logic [1:0] c, input logic [4:0] r,
                                        input logic [5:0] k);
    return {c, r[2:0], k[2:0]} ^ 8'h5A;
  endfunction

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = pend;
    mem_rsp_data  = pdata;
    pend = 0;
    mem_req_ready = (cyc % 3) != 0;
    rd_ready      = (cyc % 4) != 1;
    #1;
    if (rst_n) begin
      if (mem_req_valid && mem_req_ready) begin
        mem_acc++;
        if (mem_req_write) begin
          if (wexp.size() == 0) chk(0, "R7 unexpected write", mem_wdata, 0);
          else begin
            logic [20:0] e;
            e = wexp.pop_front();
            chk({mem_chapter, mem_row, mem_col, mem_wdata} == e, "R7/R8 mem write",
                {mem_chapter, mem_row, mem_col, mem_wdata}, e);
          end
        end else begin
          pend  = 1;
          pdata = mem_fn(mem_chapter, mem_row, mem_col);
        end
      end
      if (rd_valid && rd_ready) begin
        if (rexp.size() == 0) chk(0, "R10 unexpected read", rd_data, 0);
        else begin
          logic [7:0] e;
          e = rexp.pop_front();
          chk(rd_data == e, "R4/R5/R6 read data", rd_data, e);
        end
      end
    end
    if (cyc > 100000) begin
      chk(0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic adv();
    if (tcol >= 6'd39) begin
      tcol = 0;
      trow = (trow >= 5'd24) ? 5'd0 : trow + 5'd1;
    end else tcol = tcol + 6'd1;
  endtask

  task automatic step_ptr();
    if (bptr != 8'h0B) bptr = bptr + 8'h01;
  endtask

  task automatic drive_wr(input bit first, input logic [7:0] d);
    @(negedge clk);
    wr_first = first; wr_data = d; wr_valid = 1;
    #2;
    while (!wr_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic setptr(input logic [7:0] a);
    bptr = a;
    drive_wr(1, a);
  endtask

  task automatic wbyte(input logic [7:0] d);
    case (bptr)
      8'h00: bsel = d[0];
      8'h08: bch = d[1:0];
      8'h09: trow = d[4:0];
      8'h0A: tcol = d[5:0];
      8'h0B: begin wexp.push_back({bch, trow, tcol, d}); adv(); end
      default: ;
    endcase
    step_ptr();
    drive_wr(0, d);
  endtask

  task automatic rbyte();
    logic [7:0] e;
    e = 8'h00;
    if (bptr == 8'h0B) begin
      if (bsel) e = {rate_60hz, 6'b0, sync_good};
      else begin e = mem_fn(bch, trow, tcol); adv(); end
    end
    rexp.push_back(e);
    step_ptr();
    @(negedge clk);
    rd_req_valid = 1;
    #2;
    while (!rd_req_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    rd_req_valid = 0;
  endtask

  task automatic drain();
    while (rexp.size() != 0 || wexp.size() != 0 || !wr_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int acc0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(disp_norm == 8'h03, "R1 disp_norm", disp_norm, 3);
    chk(disp_flash == 8'h03, "R1 disp_flash", disp_flash, 3);
    chk({cfg_pins, cfg_mode, preq_ctl, preq_data, disp_page, disp_mode} == 0,
        "R1 other regs", {cfg_pins, cfg_mode, preq_ctl}, 0);
    chk({mem_chapter, mem_pkt_sel, mem_row, mem_col} == 0, "R1 access position",
        {mem_chapter, mem_pkt_sel, mem_row, mem_col}, 0);
    chk(!mem_req_valid && !rd_valid, "R1 nothing pending", {mem_req_valid, rd_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 burst from 0x00, R3 masks of reserved bits
    setptr(8'h00);
    for (int i = 0; i < 9; i++) wbyte(8'hFF);
    repeat (2) @(negedge clk);
    chk(cfg_pins == 3'h7, "R3 reg0", cfg_pins, 7);
    chk(cfg_mode == 7'h7F, "R3 reg1", cfg_mode, 8'h7F);
    chk(preq_ctl == 8'hBF, "R3 reg2 bit6 reserved", preq_ctl, 8'hBF);
    chk(preq_data == 5'h1F, "R3 reg3", preq_data, 8'h1F);
    chk(disp_page == 2'h3, "R2 burst reg4", disp_page, 3);
    chk(disp_norm == 8'hFF && disp_flash == 8'hFF && disp_mode == 8'hFF,
        "R2 burst regs5-7", disp_mode, 8'hFF);
    chk(mem_chapter == 2'h3 && mem_pkt_sel, "R9 chapter/pkt from reg8",
        {mem_pkt_sel, mem_chapter}, 7);

    // R9 row/col, R2 sticky window, R7 writes (status selected, bit0=1)
    setptr(8'h09);
    wbyte(8'hE3); wbyte(8'hC5);
    repeat (2) @(negedge clk);
    chk(mem_row == 5'd3 && mem_col == 6'd5, "R9 row/col load", {mem_row, mem_col}, {5'd3, 6'd5});
    wbyte(8'h11); wbyte(8'h22);
    drain();
    chk(mem_col == 6'd7, "R8 column stepped", mem_col, 7);

    // R5 status reads
    sync_good = 1; rate_60hz = 1;
    acc0 = mem_acc;
    rbyte();
    drain();
    sync_good = 0;
    rbyte();
    drain();
    chk(mem_acc == acc0, "R5 no memory access", mem_acc, acc0);
    chk(mem_col == 6'd7, "R5 column unchanged", mem_col, 7);

    // R6 memory reads, new chapter
    setptr(8'h00); wbyte(8'h00);
    setptr(8'h08); wbyte(8'h02);
    setptr(8'h0B);
    for (int i = 0; i < 3; i++) rbyte();
    drain();
    chk(mem_col == 6'd10 && mem_chapter == 2'd2 && !mem_pkt_sel, "R6/R8 after reads",
        {mem_chapter, mem_col}, {2'd2, 6'd10});

    // R4 write-only and unmapped
    acc0 = mem_acc;
    setptr(8'h05); rbyte();
    setptr(8'h20); rbyte();
    setptr(8'h30); wbyte(8'hAA);
    drain();
    chk(mem_acc == acc0, "R4 no memory access", mem_acc, acc0);
    chk(disp_norm == 8'hFF && cfg_pins == 3'h0 && disp_page == 2'h3, "R4 unmapped write ignored",
        disp_norm, 8'hFF);

    // R8 wrap of column and row
    setptr(8'h09); wbyte(8'd24); wbyte(8'd38);
    wbyte(8'hA1); wbyte(8'hA2); wbyte(8'hA3);
    drain();
    chk(mem_row == 5'd0 && mem_col == 6'd1, "R8 wrap to row 0", {mem_row, mem_col}, 1);

    chk(rexp.size() == 0 && wexp.size() == 0, "R10 scoreboard drained",
        rexp.size() + wexp.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule